// File: doc/BRIEF.md
# Core/DMA External Bus Slot Arbiter

This block decides who uses each free slot of a shared external bus. There are two contenders. The processor core can raise up to three requests at once: program fetch, X-data and Y-data. The DMA engine raises one request, and that request carries the 2-bit priority of its active channel. The arbiter looks at a 2-bit mode field to decide how the two sides rank. In dynamic mode it compares a stored 2-bit core priority against the DMA channel priority. In the three static modes the ranking is fixed and the stored core priority plays no part.

When both sides rank equally, the slots are shared in a rotating order: program, X, Y, DMA, then back to program. A pointer records where the next search starts. The same rotation also orders the core's own requesters whenever the core wins a slot outright. Each slot produces at most one grant, and the grant is one-hot. The grant is combinational from the current requests. The pointer and the core priority register update on the clock edge that closes the slot.

Requests and grants are plain level signals, not a valid/ready stream. A requester holds its request until it sees its grant on a cycle where `bus_free` is high. A grant means the slot is used in that cycle.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant` is all zero. Reset sets the core priority register to 3 (binary 11, the highest level) and sets the rotation pointer to program.
- R2: In mode 00 (dynamic), when both sides request and the core priority is greater than `dma_prio`, the DMA gets no grant and one core requester is granted. Priorities run from 0 (lowest) to 3 (highest).
- R3: In mode 00, when both sides request and the core priority is less than `dma_prio`, the DMA is granted (`grant[3]`).
- R4: When both sides request and the priorities are equal, grants rotate in the order program (`grant[0]`), X (`grant[1]`), Y (`grant[2]`), DMA (`grant[3]`), then back to program.
- R5: Mode 01 ranks the core below the DMA, mode 10 ranks them equal, and mode 11 ranks the core above the DMA. In these modes the stored core priority has no effect.
- R6: At most one bit of `grant` is high, and `grant` is zero whenever `bus_free` is low.
- R7: When only one side requests and `bus_free` is high, that side receives the slot whatever the priorities are.
- R8: The grant goes to the first requester that is both eligible and asserting, searching in rotation order from the pointer. Requesters that are not asserting are skipped. After a grant, the pointer moves to the position just after the granted requester. Only a requester that asserts its request is ever granted.
- R9: A high `cp_we` loads `cp_wdata` into the core priority register on the next clock edge. The new value governs dynamic-mode decisions from that point on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_free | input | 1 | External bus slot is available this cycle |
| core_req | input | 3 | Core requests: bit 0 program, bit 1 X-data, bit 2 Y-data |
| dma_req | input | 1 | DMA request from the active channel |
| dma_prio | input | 2 | Priority of the active DMA channel |
| mode | input | 2 | 00 dynamic, 01 core below DMA, 10 equal, 11 core above DMA |
| cp_we | input | 1 | Load strobe for the core priority register |
| cp_wdata | input | 2 | New core priority value |
| grant | output | 4 | One-hot grant: bit 0 program, 1 X, 2 Y, 3 DMA |

## Verification
The bench walks a full tie rotation across program, X, Y and DMA. A pointer that failed to wrap, or that advanced on slots where the bus was busy, would repeat or skip a requester. It then grants a sparse set of core requesters from a pointer in mid-rotation, which exposes a search that starts at program every time or one that stops at a requester that is not asserting. The static modes are driven with core priority and DMA priority chosen so that a design still consulting the core priority would pick the other side. The bench also writes the core priority to zero and then resets it again, which shows whether reset restores the highest level and the program pointer.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Ranking mode selected by the 2-bit mode field
  typedef enum logic [1:0] {
    MODE_DYNAMIC   = 2'b00,
    MODE_CORE_LOW  = 2'b01,
    MODE_EQUAL     = 2'b10,
    MODE_CORE_HIGH = 2'b11
  } rank_mode_e;

  // Result of comparing the two sides
  typedef enum logic [1:0] {
    RANK_CORE = 2'b00,
    RANK_DMA  = 2'b01,
    RANK_TIE  = 2'b10
  } rank_out_e;

endpackage

// File: rtl/arb_rank_cmp.sv
module arb_rank_cmp
  import arb_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  logic [1:0]        mode,
  input  logic [PRIO_W-1:0] core_prio,
  input  logic [PRIO_W-1:0] dma_prio,
  output rank_out_e         rank
);

  rank_mode_e mode_e;
  assign mode_e = rank_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      MODE_CORE_LOW:  rank = RANK_DMA;
      MODE_EQUAL:     rank = RANK_TIE;
      MODE_CORE_HIGH: rank = RANK_CORE;
      default: begin
        if (core_prio > dma_prio)      rank = RANK_CORE;
        else if (core_prio < dma_prio) rank = RANK_DMA;
        else                           rank = RANK_TIE;
      end
    endcase
  end

endmodule

// File: rtl/arb_prio_reg.sv
module arb_prio_reg #(
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PRIO_W-1:0] wdata,
  output logic [PRIO_W-1:0] prio
);

  localparam logic [PRIO_W-1:0] PRIO_TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)  prio <= PRIO_TOP;
    else if (we) prio <= wdata;
  end

endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        idx = IW'(j);
      end
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_oh
      assign onehot[g] = hit && (idx == IW'(g));
    end
  endgenerate

endmodule

// File: rtl/arb_rr_ptr.sv
module arb_rr_ptr #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [IW-1:0] granted,
  output logic [IW-1:0] ptr
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= (granted == LAST) ? '0 : granted + 1'b1;
  end

endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_CORE = 3,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_free,
  input  logic [N_CORE-1:0] core_req,
  input  logic              dma_req,
  input  logic [PRIO_W-1:0] dma_prio,
  input  logic [1:0]        mode,
  input  logic              cp_we,
  input  logic [PRIO_W-1:0] cp_wdata,
  output logic [N_CORE:0]   grant
);

  localparam int N  = N_CORE + 1;
  localparam int IW = $clog2(N);

  logic [PRIO_W-1:0] core_prio;
  rank_out_e         rank;
  logic [N-1:0]      elig;
  logic [IW-1:0]     ptr;
  logic              hit;
  logic [IW-1:0]     pick_idx;
  logic [N-1:0]      pick_oh;
  logic              slot_go;

  arb_prio_reg #(.PRIO_W(PRIO_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .we(cp_we), .wdata(cp_wdata), .prio(core_prio)
  );

  arb_rank_cmp #(.PRIO_W(PRIO_W)) u_cmp (
    .mode(mode), .core_prio(core_prio), .dma_prio(dma_prio), .rank(rank)
  );

  // Eligible set: a lone side always competes; with both present the rank prunes
  always_comb begin
    elig = {dma_req, core_req};
    if (dma_req && (|core_req)) begin
      unique case (rank)
        RANK_CORE: elig = {1'b0, core_req};
        RANK_DMA:  elig = {1'b1, {N_CORE{1'b0}}};
        default:   elig = {dma_req, core_req};
      endcase
    end
  end

  arb_rr_pick #(.N(N)) u_pick (
    .mask(elig), .start(ptr), .hit(hit), .idx(pick_idx), .onehot(pick_oh)
  );

  assign slot_go = rst_n && bus_free && hit;
  assign grant   = slot_go ? pick_oh : '0;

  arb_rr_ptr #(.N(N)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(slot_go), .granted(pick_idx), .ptr(ptr)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_CORE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_free,
  input logic [N_CORE-1:0] core_req,
  input logic              dma_req,
  input logic [1:0]        mode,
  input logic [N_CORE:0]   grant
);

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_busy_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_free |-> (grant == '0));

  a_r8_only_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~{dma_req, core_req}) == '0);

  a_r7_core_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && (|core_req) && !dma_req) |-> ((|grant[N_CORE-1:0]) && !grant[N_CORE]));

  a_r7_dma_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && dma_req && !(|core_req)) |-> grant[N_CORE]);

  a_r5_core_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && dma_req && mode == 2'b01) |-> grant[N_CORE]);

  a_r5_core_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && (|core_req) && mode == 2'b11) |-> !grant[N_CORE]);

endmodule

bind ext_bus_arbiter arb_checker #(.N_CORE(N_CORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_free(bus_free), .core_req(core_req),
  .dma_req(dma_req), .mode(mode), .grant(grant)
);

// File: tb/ext_bus_arbiter_test.sv
module ext_bus_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_free;
  logic [2:0] core_req;
  logic       dma_req;
  logic [1:0] dma_prio;
  logic [1:0] mode;
  logic       cp_we;
  logic [1:0] cp_wdata;
  logic [3:0] grant;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  ext_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .bus_free(bus_free), .core_req(core_req),
    .dma_req(dma_req), .dma_prio(dma_prio), .mode(mode), .cp_we(cp_we),
    .cp_wdata(cp_wdata), .grant(grant)
  );

  // {tag[3:0], bus_free, core_req[2:0], dma_req, dma_prio[1:0], mode[1:0], expected[3:0]}
  // Walked in order from reset with core priority 3 and pointer at program.
  localparam int NV = 14;
  localparam logic [16:0] VEC [NV] = '{
    {4'd4, 1'b1, 3'b111, 1'b1, 2'd3, 2'b00, 4'b0001}, // R4 tie -> program
    {4'd4, 1'b1, 3'b111, 1'b1, 2'd3, 2'b00, 4'b0010}, // R4 tie -> X
    {4'd4, 1'b1, 3'b111, 1'b1, 2'd3, 2'b00, 4'b0100}, // R4 tie -> Y
    {4'd4, 1'b1, 3'b111, 1'b1, 2'd3, 2'b00, 4'b1000}, // R4 tie -> DMA, wrap
    {4'd6, 1'b0, 3'b111, 1'b1, 2'd3, 2'b00, 4'b0000}, // R6 bus busy
    {4'd2, 1'b1, 3'b111, 1'b1, 2'd1, 2'b00, 4'b0001}, // R2 core above DMA
    {4'd8, 1'b1, 3'b101, 1'b1, 2'd1, 2'b00, 4'b0100}, // R8 skip idle X
    {4'd5, 1'b1, 3'b111, 1'b1, 2'd0, 2'b01, 4'b1000}, // R5 core fixed low
    {4'd5, 1'b1, 3'b010, 1'b1, 2'd3, 2'b11, 4'b0010}, // R5 core fixed high
    {4'd5, 1'b1, 3'b001, 1'b1, 2'd0, 2'b10, 4'b1000}, // R5 equal from Y pointer
    {4'd6, 1'b1, 3'b000, 1'b0, 2'd3, 2'b00, 4'b0000}, // R6 nobody asks
    {4'd7, 1'b1, 3'b000, 1'b1, 2'd0, 2'b11, 4'b1000}, // R7 DMA alone
    {4'd7, 1'b1, 3'b100, 1'b0, 2'd3, 2'b01, 4'b0100}, // R7 core alone
    {4'd8, 1'b1, 3'b011, 1'b0, 2'd0, 2'b10, 4'b0001}  // R8 wrap past DMA
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic bf, input logic [2:0] cr, input logic dr,
                       input logic [1:0] dp, input logic [1:0] md);
    bus_free = bf; core_req = cr; dma_req = dr; dma_prio = dp; mode = md;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: grant=%b expected=done", grant);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cp_we = 1'b0; cp_wdata = 2'd0;
    drive(1'b1, 3'b111, 1'b1, 2'd3, 2'b00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 grant held low in reset", grant, 4'b0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      drive(v[12], v[11:9], v[8], v[7:6], v[5:4]);
      #2;
      check($sformatf("R%0d vector %0d", v[16:13], i), grant, v[3:0]);
      @(negedge clk);
    end

    // R9: lower core priority to 0, DMA at 1 must then win in dynamic mode
    cp_we = 1'b1; cp_wdata = 2'd0;
    drive(1'b0, 3'b000, 1'b0, 2'd0, 2'b00);
    @(negedge clk);
    cp_we = 1'b0;
    drive(1'b1, 3'b111, 1'b1, 2'd1, 2'b00);
    #2;
    check("R9 written priority 0 below DMA 1", grant, 4'b1000);
    @(negedge clk);
    // R5 with priority 0 stored: mode 11 still lets the core win (pointer now program)
    drive(1'b1, 3'b111, 1'b1, 2'd3, 2'b11);
    #2;
    check("R5 stored priority ignored in static mode", grant, 4'b0001);
    @(negedge clk);

    // R1: reset restores priority 3 and pointer at program
    rst_n = 1'b0;
    drive(1'b0, 3'b000, 1'b0, 2'd0, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 3'b111, 1'b1, 2'd2, 2'b00);
    #2;
    check("R1 priority back to 3 and pointer at program", grant, 4'b0001);
    @(negedge clk);
    // R3: DMA at 3 ties with core 3; DMA at higher needs lower core, so store 1
    cp_we = 1'b1; cp_wdata = 2'd1;
    drive(1'b0, 3'b000, 1'b0, 2'd0, 2'b00);
    @(negedge clk);
    cp_we = 1'b0;
    drive(1'b1, 3'b111, 1'b1, 2'd2, 2'b00);
    #2;
    check("R3 core 1 below DMA 2", grant, 4'b1000);
    @(negedge clk);

    finish_run();
  end

endmodule